// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns a CPU's write to the software-interrupt register into pending state on one or more CPUs of a small multiprocessor cluster. Each written word names one of 16 software interrupt IDs, a list of target CPUs and a filter mode. The block works out the final target set from the writer's CPU number and the number of CPUs online. For every target, it records the writer in a per-ID bitmap of source CPUs.

A second access port gives byte-wide views of these source bitmaps. The set view ORs bits into a bitmap and the clear view removes them. Both views read back the same bitmap bytes. A per-CPU output is high while any software interrupt of that CPU has a non-zero source bitmap. Priority selection, acknowledge and end-of-interrupt belong to other logic.

Top module: `sgi_dispatch`

## Requirements
- R1: A software-interrupt word carries the interrupt ID in bits [3:0], the target list in bits [23:16] (bit n is CPU n) and the filter mode in bits [25:24]. All other bits are ignored.
- R2: Mode 0 targets the CPUs in the target list. Target bits at or above `cpu_count` are dropped.
- R3: Mode 1 targets every CPU below `cpu_count` except the writer, whatever the target list holds.
- R4: Mode 2 targets only the writing CPU.
- R5: Mode 3 is reserved. Such a write changes no bitmap.
- R6: For each target CPU, a software-interrupt write ORs bit `sgi_cpu` into that CPU's bitmap for the given ID. Bits already present are kept. `cpu_pending[c]` is 1 exactly when some ID of CPU c has a non-zero bitmap.
- R7: Register reads return one byte per ID of CPU `acc_cpu`. A byte access (`acc_wide`=0) returns ID `acc_off` in bits [7:0], with the upper bits zero. A word access uses the four IDs starting at `acc_off` with its low two bits cleared, lowest ID in bits [7:0].
- R8: A write with `acc_clr`=0 ORs each data byte into the bitmap of its ID. A zero byte leaves both the bitmap and the pending output unchanged.
- R9: A write with `acc_clr`=1 clears, in each addressed bitmap, the bits set in the data byte. Once every bitmap of a CPU is zero, its `cpu_pending` bit falls.
- R10: When a register write and a software-interrupt write reach the same bitmap in one cycle, the register write is applied first and the software-interrupt bit second.
- R11: After reset all bitmaps are zero and `cpu_pending` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_count | input | 4 | Number of online CPUs, 1 to NCPU |
| sgi_we | input | 1 | Software-interrupt register write strobe |
| sgi_cpu | input | 3 | CPU number of the writer |
| sgi_wdata | input | 32 | Software-interrupt write word |
| acc_en | input | 1 | Register access valid |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_clr | input | 1 | Write selects clear view (1) or set view (0) |
| acc_wide | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| acc_cpu | input | 3 | CPU whose bitmaps are accessed |
| acc_off | input | 4 | First interrupt ID of the access |
| acc_wdata | input | 32 | Register write data |
| acc_rdata | output | 32 | Register read data, combinational, zero when idle |
| cpu_pending | output | 8 | Per-CPU software interrupt pending |

## Verification
The software-interrupt path is driven in all four filter modes. The mode 0 test uses a target list that includes CPUs above the online count, which shows whether out-of-range bits are masked. The mode 1 test uses a list of all ones, which shows whether the list is ignored and the writer is excluded. The mode 3 test uses a word whose other fields would hit every CPU, so any stray update appears. A second writer hitting the same ID shows that bits are ORed rather than replaced. Register accesses cover byte and word sizes, an unaligned word offset, a zero set byte and partial clears ahead of a full clear. A clear and a software-interrupt write are issued in the same cycle to check the order in which they are applied.

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NCPU = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NCPU+1)-1:0]   cpu_count,
  input  logic                        sgi_we,
  input  logic [$clog2(NCPU)-1:0]     sgi_cpu,
  input  logic [31:0]                 sgi_wdata,
  input  logic                        acc_en,
  input  logic                        acc_wr,
  input  logic                        acc_clr,
  input  logic                        acc_wide,
  input  logic [$clog2(NCPU)-1:0]     acc_cpu,
  input  logic [3:0]                  acc_off,
  input  logic [31:0]                 acc_wdata,
  output logic [31:0]                 acc_rdata,
  output logic [NCPU-1:0]             cpu_pending
);
  localparam int NID = 16;
  localparam int FLAT = NCPU * NID * NCPU;

  logic [NCPU-1:0] src     [NCPU][NID];
  logic [NCPU-1:0] src_nxt [NCPU][NID];
  logic [FLAT-1:0] src_flat;

  wire [3:0]      sid   = sgi_wdata[3:0];
  wire [NCPU-1:0] tlist = sgi_wdata[16 +: NCPU];
  wire [1:0]      mode  = sgi_wdata[25:24];
  wire [3:0]      base  = acc_wide ? {acc_off[3:2], 2'b00} : acc_off;
  wire            regw  = acc_en && acc_wr;

  logic [NCPU-1:0] online, self, tgt;

  always_comb begin
    online = '0;
    self   = '0;
    for (int c = 0; c < NCPU; c++) online[c] = (c < int'(cpu_count));
    self[sgi_cpu] = 1'b1;
    case (mode)
      2'd0:    tgt = tlist & online;
      2'd1:    tgt = online & ~self;
      2'd2:    tgt = self & online;
      default: tgt = '0;
    endcase
  end

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      for (int i = 0; i < NID; i++) begin
        logic [3:0] lane;
        logic       hit;
        logic [NCPU-1:0] b;
        lane = 4'(i) - base;
        hit  = regw && (acc_cpu == c[$clog2(NCPU)-1:0]) &&
               (acc_wide ? (lane < 4'd4) : (lane == 4'd0));
        b    = acc_wdata[lane[1:0]*8 +: NCPU];
        src_nxt[c][i] = src[c][i];
        if (hit) src_nxt[c][i] = acc_clr ? (src[c][i] & ~b) : (src[c][i] | b);
        if (sgi_we && tgt[c] && (sid == 4'(i))) src_nxt[c][i][sgi_cpu] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCPU; c++)
      for (int i = 0; i < NID; i++)
        src[c][i] <= rst_n ? src_nxt[c][i] : '0;
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_en)
      for (int k = 0; k < 4; k++)
        if (acc_wide || k == 0) acc_rdata[k*8 +: NCPU] = src[acc_cpu][base + 4'(k)];
  end

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      cpu_pending[c] = 1'b0;
      for (int i = 0; i < NID; i++) begin
        cpu_pending[c] = cpu_pending[c] | (|src[c][i]);
        src_flat[(c*NID + i)*NCPU +: NCPU] = src[c][i];
      end
    end
  end
endmodule

module sgi_dispatch_chk #(
  parameter int NCPU = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [$clog2(NCPU+1)-1:0]   cpu_count,
  input logic                        sgi_we,
  input logic [$clog2(NCPU)-1:0]     sgi_cpu,
  input logic [31:0]                 sgi_wdata,
  input logic                        acc_en,
  input logic                        acc_wr,
  input logic                        acc_clr,
  input logic                        acc_wide,
  input logic [31:0]                 acc_rdata,
  input logic [NCPU-1:0]             cpu_pending,
  input logic [NCPU*16*NCPU-1:0]     src_flat
);
  a_r4_self_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (sgi_we && sgi_wdata[25:24] == 2'd2 && int'(sgi_cpu) < int'(cpu_count) && !acc_en)
    |=> cpu_pending[sgi_cpu]);

  a_r5_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (sgi_we && sgi_wdata[25:24] == 2'd3 && !(acc_en && acc_wr)) |=> $stable(src_flat));

  a_r7_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wide) |-> (acc_rdata[31:8] == 24'd0));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sgi_we && !(acc_en && acc_wr)) |=> $stable(src_flat));

  a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_pending != '0 && !(acc_en && acc_wr && acc_clr)) |=> ((cpu_pending & $past(cpu_pending)) == $past(cpu_pending)));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_count(cpu_count), .sgi_we(sgi_we),
  .sgi_cpu(sgi_cpu), .sgi_wdata(sgi_wdata), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_clr(acc_clr), .acc_wide(acc_wide), .acc_rdata(acc_rdata),
  .cpu_pending(cpu_pending), .src_flat(src_flat)
);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  cpu_count = 4'd4;
  logic        sgi_we = 0;
  logic [2:0]  sgi_cpu = 0;
  logic [31:0] sgi_wdata = 0;
  logic        acc_en = 0, acc_wr = 0, acc_clr = 0, acc_wide = 0;
  logic [2:0]  acc_cpu = 0;
  logic [3:0]  acc_off = 0;
  logic [31:0] acc_wdata = 0;
  logic [31:0] acc_rdata;
  logic [7:0]  cpu_pending;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sgi_dispatch u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sword(int mode, logic [7:0] t, int id);
    return (32'(mode) << 24) | (32'(t) << 16) | 32'(id);
  endfunction

  task automatic sgi(int cpu, logic [31:0] w);
    @(negedge clk);
    sgi_we = 1; sgi_cpu = 3'(cpu); sgi_wdata = w;
    @(negedge clk);
    sgi_we = 0;
  endtask

  task automatic rd(int cpu, int off, bit wide, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_cpu = 3'(cpu); acc_off = 4'(off); acc_wide = wide;
    #1 d = acc_rdata;
    acc_en = 0;
  endtask

  task automatic wr(int cpu, int off, bit wide, bit clr, logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_cpu = 3'(cpu); acc_off = 4'(off);
    acc_wide = wide; acc_clr = clr; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 0, 1, d); chk("R11 bitmap cpu0", d, 0);
    rd(7, 12, 1, d); chk("R11 bitmap cpu7", d, 0);
    chk("R11 pending", 32'(cpu_pending), 0);
  endtask

  task automatic t_mode0();
    logic [31:0] d;
    sgi(1, sword(0, 8'h96, 5) | 32'h0000_FFF0);
    rd(1, 5, 0, d); chk("R2 cpu1 id5", d, 32'h02);
    rd(2, 5, 0, d); chk("R1 cpu2 id5", d, 32'h02);
    rd(4, 5, 0, d); chk("R2 cpu4 dropped", d, 0);
    rd(7, 5, 0, d); chk("R2 cpu7 dropped", d, 0);
    chk("R6 pending after mode0", 32'(cpu_pending), 32'h06);
  endtask

  task automatic t_mode1();
    logic [31:0] d;
    sgi(2, sword(1, 8'hFF, 3));
    rd(0, 3, 0, d); chk("R3 cpu0 id3", d, 32'h04);
    rd(3, 3, 0, d); chk("R3 cpu3 id3", d, 32'h04);
    rd(2, 3, 0, d); chk("R3 writer excluded", d, 0);
    rd(5, 3, 0, d); chk("R3 offline cpu5", d, 0);
    chk("R3 pending", 32'(cpu_pending), 32'h0F);
  endtask

  task automatic t_mode2();
    logic [31:0] d;
    sgi(3, sword(2, 8'h01, 15));
    rd(3, 15, 0, d); chk("R4 cpu3 id15", d, 32'h08);
    rd(0, 15, 0, d); chk("R4 list ignored", d, 0);
  endtask

  task automatic t_mode3();
    logic [31:0] d;
    sgi(0, sword(3, 8'hFF, 0));
    rd(1, 0, 0, d); chk("R5 cpu1 id0", d, 0);
    rd(3, 0, 0, d); chk("R5 cpu3 id0", d, 0);
    chk("R5 pending unchanged", 32'(cpu_pending), 32'h0F);
  endtask

  task automatic t_views();
    logic [31:0] d;
    rd(0, 0, 1, d); chk("R7 word read ids0-3", d, 32'h0400_0000);
    wr(0, 8, 0, 0, 32'h0);
    rd(0, 8, 0, d); chk("R8 zero byte", d, 0);
    wr(0, 8, 1, 0, 32'h1122_3300);
    rd(0, 9, 1, d); chk("R7 unaligned word read", d, 32'h1122_3300);
    rd(0, 10, 0, d); chk("R7 byte read id10", d, 32'h22);
    wr(0, 10, 0, 0, 32'h0000_0041);
    rd(0, 10, 0, d); chk("R8 or into bitmap", d, 32'h63);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(0, 9, 0, 1, 32'h03);
    rd(0, 9, 0, d); chk("R9 partial clear", d, 32'h30);
    wr(0, 3, 0, 1, 32'h04);
    chk("R9 pending held", 32'(cpu_pending[0]), 1);
    wr(0, 8, 1, 1, 32'hFFFF_FFFF);
    rd(0, 8, 1, d); chk("R9 word clear", d, 0);
    chk("R9 pending fell", 32'(cpu_pending), 32'h0E);
  endtask

  task automatic t_order();
    logic [31:0] d;
    cpu_count = 4'd8;
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_cpu = 3'd1; acc_off = 4'd5; acc_wide = 0;
    acc_clr = 1; acc_wdata = 32'hFF;
    sgi_we = 1; sgi_cpu = 3'd6; sgi_wdata = sword(0, 8'h02, 5);
    @(negedge clk);
    acc_en = 0; acc_wr = 0; sgi_we = 0;
    rd(1, 5, 0, d); chk("R10 clear then set", d, 32'h40);
    sgi(1, sword(2, 8'h00, 5));
    rd(1, 5, 0, d); chk("R6 sources ored", d, 32'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_views();
    t_clear();
    t_order();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule